// File: doc/BRIEF.md
# MMU Access Fault Checker

This block judges a single memory access against the translation descriptors that a table walk has already returned. It then decides whether the access may go ahead. Each cycle it can take one request: the address, the access size, whether it is a read, a write or an instruction fetch, and whether the requester is privileged. With the request come the first-level descriptor, the second-level descriptor when the first level points at a page table, and the 32-bit domain access control word.

One clock later it answers with a fault flag, a three-bit fault class and a flag that tells a section mapping from a page mapping. It also raises a grant signal. Grant releases the external memory access and the TLB fill, and it stays low whenever any fault is found. That keeps a faulting address off the bus and a bad translation out of the TLB.

The checks run in a fixed priority order. Alignment comes first, then translation, then domain, then permission, and only the highest-priority fault is reported. Translation, domain and permission faults each have a section form and a page form, so every class code names one exact cause.

Top module: `mmu_fault_check`

## Requirements
- R1: While rst_n is low at a rising clock edge, every output is 0 after that edge, whatever the request inputs are.
- R2: Outputs describe the request sampled at the previous rising edge. rsp_valid is req_valid delayed by one cycle. When req_valid was 0, flt_valid, flt_class, flt_page and grant are all 0.
- R3: req_size selects the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. An access is misaligned when any of the low log2(size) address bits is 1. A misaligned access reports class 1 (alignment), which overrides every other fault.
- R4: First-level descriptor bits [1:0] decode as follows: 10 is a section, 01 points at a page table, and 00 or 11 is invalid. An invalid first-level descriptor on an aligned access reports class 2 (section translation).
- R5: When the first level is 01, second-level descriptor bits [1:0] equal to 00 report class 3 (page translation). Any other second-level value is valid. The second-level descriptor is ignored for sections.
- R6: The domain number is first-level bits [8:5], and its two-bit field is dacr[2n+1:2n]. Once translation passes, a field of 00 or 10 reports a domain fault: class 4 for a section, class 5 for a page.
- R7: A domain field of 11 (manager) skips the permission check, so a translated access in such a domain reports no fault.
- R8: A domain field of 01 (client) checks the access-permission pair. The pair comes from first-level bits [11:10] for a section and from second-level bits [5:4] for a page. The codes are: 00 denies everything; 01 allows privileged access only; 10 allows any privileged access and user reads; 11 allows everything. A denied access reports class 6 for a section and class 7 for a page.
- R9: An instruction fetch (req_fetch=1) is judged as a read, whatever the value of req_write.
- R10: grant is 1 exactly when rsp_valid is 1 and flt_class is 0 (none). Any fault holds grant at 0.
- R11: flt_page is 1 when the answered request had first-level bits [1:0] equal to 01, including for alignment faults, and is 0 otherwise.
- R12: flt_valid is 1 exactly when flt_class is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 32 | Virtual address of the access |
| req_size | input | 2 | Log2 of the access size in bytes |
| req_write | input | 1 | Write access when set |
| req_fetch | input | 1 | Instruction fetch when set |
| req_priv | input | 1 | Privileged requester when set |
| l1_desc | input | 32 | First-level descriptor |
| l2_desc | input | 32 | Second-level descriptor, used for pages |
| dacr | input | 32 | Domain access control word, 2 bits per domain |
| rsp_valid | output | 1 | A response is present |
| flt_valid | output | 1 | The answered access faulted |
| flt_class | output | 3 | Fault class code, 0 to 7 |
| flt_page | output | 1 | The answered access used a page mapping |
| grant | output | 1 | Permission for the external access and the TLB fill |

## Verification
The assertions assume two things: that the descriptor and control inputs are settled whenever req_valid is high, and that l2_desc means something only when the first-level type is a page pointer. The sweep keeps to these by driving every field on the inactive edge. It also puts the opposite permission pair in whichever descriptor should be ignored, so a wrong selection shows at the outputs. In the DACR, only the chosen domain holds the field under test and every other domain holds a different value, so a wrong domain index changes the reported class.

// File: rtl/mmu_fchk_pkg.sv
// Package: shared types for the access fault checker.
// Assumes: class codes are fixed and visible to the consumers of flt_class.
package mmu_fchk_pkg;

    typedef enum logic [2:0] {
        FC_NONE      = 3'd0,
        FC_ALIGN     = 3'd1,
        FC_XLAT_SEC  = 3'd2,
        FC_XLAT_PAGE = 3'd3,
        FC_DOM_SEC   = 3'd4,
        FC_DOM_PAGE  = 3'd5,
        FC_PERM_SEC  = 3'd6,
        FC_PERM_PAGE = 3'd7
    } fault_class_e;

    typedef enum logic [1:0] {
        L1K_INVALID = 2'b00,
        L1K_TABLE   = 2'b01,
        L1K_SECTION = 2'b10,
        L1K_RSVD    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        DOM_NOACC   = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_field_e;

    typedef enum logic [1:0] {
        AP_DENY     = 2'b00,
        AP_PRIV     = 2'b01,
        AP_USER_RO  = 2'b10,
        AP_FULL     = 2'b11
    } ap_code_e;

endpackage

// File: rtl/mfc_align_chk.sv
// Module: alignment check for one access.
// Assumes: req_size is log2 of the byte count; the largest size sets how
// many low address bits can be examined.
module mfc_align_chk #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              misaligned
);
    localparam int MAX_LG = (1 << SIZE_W) - 1;

    logic [MAX_LG-1:0] bad_bit;

    // One term per low address bit: set when the bit must be zero for this size.
    for (genvar i = 0; i < MAX_LG; i++) begin : g_bit
        assign bad_bit[i] = addr[i] && (size > SIZE_W'(i));
    end

    // Any offending bit marks the access misaligned.
    assign misaligned = |bad_bit;

endmodule

// File: rtl/mfc_desc_decode.sv
// Module: decodes the first- and second-level descriptors.
// Assumes: l2 is meaningful only when the first level is a table pointer;
// domain and permission fields sit at fixed positions given by parameters.
module mfc_desc_decode
    import mmu_fchk_pkg::*;
#(
    parameter int DESC_W    = 32,
    parameter int DOM_W     = 4,
    parameter int DOM_LSB   = 5,
    parameter int L1_AP_LSB = 10,
    parameter int L2_AP_LSB = 4
) (
    input  logic [DESC_W-1:0] l1,
    input  logic [DESC_W-1:0] l2,
    output logic              l1_bad,
    output logic              is_page,
    output logic              l2_bad,
    output logic [DOM_W-1:0]  dom_idx,
    output logic [1:0]        ap
);
    l1_kind_e kind;

    // Extract the first-level type field.
    assign kind = l1_kind_e'(l1[1:0]);

    // Classify the first-level descriptor.
    always_comb begin
        l1_bad  = 1'b0;
        is_page = 1'b0;
        unique case (kind)
            L1K_INVALID: l1_bad  = 1'b1;
            L1K_RSVD:    l1_bad  = 1'b1;
            L1K_TABLE:   is_page = 1'b1;
            default:     ;
        endcase
    end

    // Second level is invalid only on its zero type.
    assign l2_bad  = (l2[1:0] == 2'b00);

    // Domain number always comes from the first level.
    assign dom_idx = l1[DOM_LSB +: DOM_W];

    // Permission pair comes from the level that made the final mapping.
    assign ap = is_page ? l2[L2_AP_LSB +: 2] : l1[L1_AP_LSB +: 2];

endmodule

// File: rtl/mfc_dom_perm.sv
// Module: domain field lookup and access-permission check.
// Assumes: dacr holds two bits per domain, domain 0 in the lowest pair;
// fetches arrive already folded into reads.
module mfc_dom_perm
    import mmu_fchk_pkg::*;
#(
    parameter int DOM_W = 4
) (
    input  logic [2*(1<<DOM_W)-1:0] dacr,
    input  logic [DOM_W-1:0]        dom_idx,
    input  logic [1:0]              ap,
    input  logic                    is_write,
    input  logic                    is_priv,
    output logic                    dom_fault,
    output logic                    dom_mgr,
    output logic                    perm_fault
);
    localparam int NUM_DOM = 1 << DOM_W;

    logic [1:0] fld [NUM_DOM];
    dom_field_e sel;
    logic       perm_ok;

    // Split the control word into one field per domain.
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign fld[d] = dacr[2*d +: 2];
    end

    // Select the field of the addressed domain.
    assign sel = dom_field_e'(fld[dom_idx]);

    // Decode domain behaviour from the selected field.
    always_comb begin
        dom_fault = 1'b0;
        dom_mgr   = 1'b0;
        unique case (sel)
            DOM_NOACC:   dom_fault = 1'b1;
            DOM_RSVD:    dom_fault = 1'b1;
            DOM_MANAGER: dom_mgr   = 1'b1;
            default:     ;
        endcase
    end

    // Evaluate the permission pair for this requester and direction.
    always_comb begin
        unique case (ap_code_e'(ap))
            AP_DENY:    perm_ok = 1'b0;
            AP_PRIV:    perm_ok = is_priv;
            AP_USER_RO: perm_ok = is_priv || !is_write;
            default:    perm_ok = 1'b1;
        endcase
    end

    // Permission is only consulted for client domains.
    assign perm_fault = (sel == DOM_CLIENT) && !perm_ok;

endmodule

// File: rtl/mfc_fault_prio.sv
// Module: picks the single fault to report from the individual checks.
// Assumes: each input check is valid on its own; ordering is done here only.
module mfc_fault_prio
    import mmu_fchk_pkg::*;
(
    input  logic         misaligned,
    input  logic         l1_bad,
    input  logic         is_page,
    input  logic         l2_bad,
    input  logic         dom_fault,
    input  logic         perm_fault,
    output fault_class_e cls
);
    // Walk the checks from highest to lowest priority.
    always_comb begin
        if (misaligned)
            cls = FC_ALIGN;
        else if (l1_bad)
            cls = FC_XLAT_SEC;
        else if (is_page && l2_bad)
            cls = FC_XLAT_PAGE;
        else if (dom_fault)
            cls = is_page ? FC_DOM_PAGE : FC_DOM_SEC;
        else if (perm_fault)
            cls = is_page ? FC_PERM_PAGE : FC_PERM_SEC;
        else
            cls = FC_NONE;
    end

endmodule

// File: rtl/mmu_fault_check.sv
// Module: top of the access fault checker. One request per cycle, answer
// registered one cycle later; grant gates the external access and TLB fill.
// Assumes: descriptor and control inputs are stable while req_valid is high.
module mmu_fault_check
    import mmu_fchk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DESC_W    = 32,
    parameter int SIZE_W    = 2,
    parameter int DOM_W     = 4,
    parameter int DOM_LSB   = 5,
    parameter int L1_AP_LSB = 10,
    parameter int L2_AP_LSB = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [SIZE_W-1:0]          req_size,
    input  logic                       req_write,
    input  logic                       req_fetch,
    input  logic                       req_priv,
    input  logic [DESC_W-1:0]          l1_desc,
    input  logic [DESC_W-1:0]          l2_desc,
    input  logic [2*(1<<DOM_W)-1:0]    dacr,
    output logic                       rsp_valid,
    output logic                       flt_valid,
    output logic [2:0]                 flt_class,
    output logic                       flt_page,
    output logic                       grant
);
    logic             misaligned;
    logic             l1_bad;
    logic             is_page;
    logic             l2_bad;
    logic [DOM_W-1:0] dom_idx;
    logic [1:0]       ap;
    logic             dom_fault;
    logic             dom_mgr;
    logic             perm_fault;
    logic             eff_write;
    fault_class_e     cls;

    // Fetches are judged as reads.
    assign eff_write = req_write && !req_fetch;

    mfc_align_chk #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_align (
        .addr       (req_addr),
        .size       (req_size),
        .misaligned (misaligned)
    );

    mfc_desc_decode #(
        .DESC_W    (DESC_W),
        .DOM_W     (DOM_W),
        .DOM_LSB   (DOM_LSB),
        .L1_AP_LSB (L1_AP_LSB),
        .L2_AP_LSB (L2_AP_LSB)
    ) u_decode (
        .l1      (l1_desc),
        .l2      (l2_desc),
        .l1_bad  (l1_bad),
        .is_page (is_page),
        .l2_bad  (l2_bad),
        .dom_idx (dom_idx),
        .ap      (ap)
    );

    mfc_dom_perm #(
        .DOM_W (DOM_W)
    ) u_domperm (
        .dacr       (dacr),
        .dom_idx    (dom_idx),
        .ap         (ap),
        .is_write   (eff_write),
        .is_priv    (req_priv),
        .dom_fault  (dom_fault),
        .dom_mgr    (dom_mgr),
        .perm_fault (perm_fault)
    );

    mfc_fault_prio u_prio (
        .misaligned (misaligned),
        .l1_bad     (l1_bad),
        .is_page    (is_page),
        .l2_bad     (l2_bad),
        .dom_fault  (dom_fault),
        .perm_fault (perm_fault),
        .cls        (cls)
    );

    // Register the verdict; idle cycles and reset give an all-zero answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            flt_valid <= 1'b0;
            flt_class <= 3'd0;
            flt_page  <= 1'b0;
            grant     <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                flt_valid <= (cls != FC_NONE);
                flt_class <= cls;
                flt_page  <= is_page;
                grant     <= (cls == FC_NONE);
            end else begin
                flt_valid <= 1'b0;
                flt_class <= 3'd0;
                flt_page  <= 1'b0;
                grant     <= 1'b0;
            end
        end
    end

    // R2: no request, quiet answer.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!flt_valid && !grant && !flt_page && flt_class == 3'd0));

    // R2: every request gets a response one cycle later.
    p_rsp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3: misalignment wins over every other check.
    p_align_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misaligned) |=> (flt_class == FC_ALIGN));

    // R4: bad first level on an aligned access is a section translation fault.
    p_l1_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misaligned && l1_bad) |=> (flt_class == FC_XLAT_SEC));

    // R7: a manager domain never yields a permission or domain fault.
    p_manager_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misaligned && !l1_bad && !(is_page && l2_bad) && dom_mgr)
        |=> (flt_class == FC_NONE));

    // R10: grant only on a clean response.
    p_grant_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (rsp_valid && flt_class == FC_NONE));

    // R11: page-variant classes always carry the page flag.
    p_page_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_class == FC_XLAT_PAGE || flt_class == FC_DOM_PAGE ||
         flt_class == FC_PERM_PAGE) |-> flt_page);

    // R12: fault flag agrees with the class code.
    p_valid_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid == (flt_class != 3'd0));

endmodule

// File: tb/sim_mmu_fault_check.sv
`timescale 1ns/1ps
module sim_mmu_fault_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic        req_priv = 1'b0;
    logic [31:0] l1_desc = '0;
    logic [31:0] l2_desc = '0;
    logic [31:0] dacr = '0;
    logic        rsp_valid;
    logic        flt_valid;
    logic [2:0]  flt_class;
    logic        flt_page;
    logic        grant;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic       pend = 1'b0;
    logic [2:0] exp_cls = '0;
    logic       exp_pg = 1'b0;
    string      exp_tag = "";

    always #2.5 clk = ~clk;

    mmu_fault_check u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_write (req_write),
        .req_fetch (req_fetch),
        .req_priv  (req_priv),
        .l1_desc   (l1_desc),
        .l2_desc   (l2_desc),
        .dacr      (dacr),
        .rsp_valid (rsp_valid),
        .flt_valid (flt_valid),
        .flt_class (flt_class),
        .flt_page  (flt_page),
        .grant     (grant)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference classifier written from the requirements.
    function automatic logic [2:0] model(input int sz, input int off, input int l1t,
                                         input int l2t, input int df, input int ap,
                                         input bit wr, input bit fe, input bit pv);
        bit w = wr && !fe;                       // R9
        bit pg = (l1t == 1);
        bit ok;
        if ((off % (1 << sz)) != 0) return 3'd1; // R3
        if (l1t == 0 || l1t == 3) return 3'd2;   // R4
        if (pg && l2t == 0) return 3'd3;         // R5
        if (df == 0 || df == 2) return pg ? 3'd5 : 3'd4; // R6
        if (df == 3) return 3'd0;                // R7
        case (ap)                                // R8
            0: ok = 0;
            1: ok = pv;
            2: ok = pv || !w;
            default: ok = 1;
        endcase
        if (!ok) return pg ? 3'd7 : 3'd6;
        return 3'd0;
    endfunction

    task automatic check_pending();
        if (pend) begin
            chk(exp_tag, flt_class, exp_cls);
            chk("R12 flt_valid", flt_valid, exp_cls != 0);
            chk("R11 flt_page", flt_page, exp_pg);
            chk("R10 grant", grant, exp_cls == 0);
            chk("R2 rsp_valid", rsp_valid, 1);
        end
    endtask

    initial begin : watchdog
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int n;
        // R1: a request during reset must not show.
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h3; req_size = 2'd2; l1_desc = 32'h0;
        @(negedge clk); @(negedge clk);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 flt_valid", flt_valid, 0);
        chk("R1 flt_class", flt_class, 0);
        chk("R1 grant", grant, 0);
        // R2: idle cycle with faulting inputs stays quiet.
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle rsp_valid", rsp_valid, 0);
        chk("R2 idle flt_valid", flt_valid, 0);
        chk("R2 idle flt_class", flt_class, 0);
        chk("R2 idle flt_page", flt_page, 0);
        chk("R2 idle grant", grant, 0);

        n = 0;
        for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
        for (int l1t = 0; l1t < 4; l1t++)
        for (int l2t = 0; l2t < 4; l2t++)
        for (int df = 0; df < 4; df++)
        for (int ap = 0; ap < 4; ap++)
        for (int op = 0; op < 8; op++) begin
            bit wr = op[0];
            bit fe = op[1];
            bit pv = op[2];
            int dom = n % 16;
            int other = (df + 1) % 4;
            logic [31:0] dw;
            @(negedge clk);
            check_pending();
            for (int d = 0; d < 16; d++)
                dw[2*d +: 2] = (d == dom) ? 2'(df) : 2'(other);
            req_valid = 1'b1;
            req_addr  = {(32'(n) * 32'h9E37) & 32'hFFFF_FFF8} | 32'(off);
            req_size  = 2'(sz);
            req_write = wr;
            req_fetch = fe;
            req_priv  = pv;
            l1_desc   = 32'(n) << 12;
            l1_desc[1:0]   = 2'(l1t);
            l1_desc[8:5]   = 4'(dom);
            l1_desc[11:10] = (l1t == 2) ? 2'(ap) : ~2'(ap);
            l2_desc   = 32'(n) << 8;
            l2_desc[1:0]   = 2'(l2t);
            l2_desc[5:4]   = (l1t == 1) ? 2'(ap) : ~2'(ap);
            dacr      = dw;
            exp_cls = model(sz, off, l1t, l2t, df, ap, wr, fe, pv);
            exp_pg  = (l1t == 1);
            case (exp_cls)
                3'd1: exp_tag = "R3 align";
                3'd2: exp_tag = "R4 l1 translation";
                3'd3: exp_tag = "R5 l2 translation";
                3'd4, 3'd5: exp_tag = "R6 domain";
                3'd6, 3'd7: exp_tag = "R8 permission";
                default: exp_tag = (df == 3) ? "R7 manager" : "R8 R9 allowed";
            endcase
            pend = 1'b1;
            n++;
        end
        @(negedge clk);
        check_pending();
        pend = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 drop rsp_valid", rsp_valid, 0);
        chk("R10 drop grant", grant, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule